// File: doc/BRIEF.md
# TFT Panel Line Timing Generator

This block produces the per-line control waveforms that a TFT panel's column (source) drivers and row (gate) drivers need. A line-start strobe, derived elsewhere from the horizontal sync reference, restarts an internal unit counter. All pulse positions and widths are then counted in shift-clock units. One unit is a fixed number of master-clock periods, three by default. A five-entry timing table, chosen by a 3-bit resolution code, supplies the width and offset of every pulse.

The outputs are three overlapping source shift clocks, an active-low horizontal sync, two output-enable pulses, a gate shift clock, a compare pulse that spans half of a line, and a sample-and-hold control. There is also a one-unit source start pulse. That pulse goes to either the right-hand or the left-hand start pin, chosen by a scan-direction input. Each start pin has its own drive enable, so the unused pin can be left floating at the pad. The resolution code is sampled only at a line start. Every output leaves a register, so no output glitches.

Top module: `lcd_line_timer`

## Requirements
- R1: The resolution code {mode_sel[2], mode_sel[1], mode_sel[0]} selects the timing table. The codes are 3'b110 for 220x280, 3'b111 for 234x480, 3'b100 for 220x528, 3'b101 for 234x960 and 3'b001 for 234x1152. The 234x480 table applies after reset.
- R2: The shift clocks src_ck[0..2] each have a period of 2 units (6 clocks) and stay high for 1 unit. src_ck[1] lags src_ck[0] by one clock and src_ck[2] lags by two. Relative to a line start, src_ck[0] is high in the first 3 clocks of each 6.
- R3: Let unit u be the u-th unit after the clock edge that samples line_start high. Every output reflects unit u during clocks 3u+1 to 3u+3 after that edge. hsync_n is low for units 0 up to HSY-1, where HSY is 9, 15, 18, 30 or 36 for 280, 480, 528, 960 or 1152.
- R4: oe_h is high for units [o, o+w), with (o,w) = 5/2, 8/3, 8/5, 14/7 and 18/9 in the same mode order. gate_ck uses 4/11, 6/20, 7/24, 12/40 and 14/50. oe_v uses 3/10, 2/13, 1/14, 4/26 and 12/40.
- R5: sh_ctl is low for the first D units of a line and high for the rest of the line, where D is 16, 27, 27, 54 or 62. In the 234x960 and 234x1152 modes it stays low for the whole line.
- R6: The start pulse is high for exactly unit D of the line. When lr_scan is 1, it drives start_r with start_r_en=1, and start_l and start_l_en are 0. When lr_scan is 0 the roles swap. The enables follow lr_scan one clock later.
- R7: cmp_pulse rises at unit C and stays high for floor(N/2) units, where N is the length of the previous line in units. C is 6, 10, 12, 20 or 26. It is clipped at the next line start, and it stays low in the first line after reset.
- R8: A change of mode_sel has no effect until the next line start. The codes 3'b000, 3'b010 and 3'b011 leave the current table in use.
- R9: During reset, hsync_n is 1 and every other output is 0. Until the first line start, hsync_n stays 1 and oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl and both start data pins stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | One-clock strobe that starts a line |
| mode_sel | input | 3 | Resolution code |
| lr_scan | input | 1 | Start pin choice: 1 selects the right pin, 0 the left pin |
| src_ck | output | 3 | Three-phase source shift clocks |
| hsync_n | output | 1 | Horizontal sync, active low |
| oe_h | output | 1 | Source output enable pulse |
| oe_v | output | 1 | Second output enable pulse |
| gate_ck | output | 1 | Gate driver shift clock |
| cmp_pulse | output | 1 | Half-line compare pulse |
| sh_ctl | output | 1 | Sample-and-hold control |
| start_r | output | 1 | Right start pin data |
| start_r_en | output | 1 | Right start pin drive enable |
| start_l | output | 1 | Left start pin data |
| start_l_en | output | 1 | Left start pin drive enable |

## Verification
The bench uses the defaults: a 10-bit unit counter, three clocks per unit and three clock phases. This gives a one-clock phase step that can be sampled directly. The 10-bit counter allows lines of 120 and 90 units, long enough for the widest table window in every mode to close inside the line. The two line lengths also show that the compare pulse follows the length of the previous line and is clipped by the next line start. Each unit is sampled in its middle clock. This measures the first unit and the unit count of every window in all five modes, with both scan directions.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

   typedef enum logic [2:0] {
      RES_220X280  = 3'd0,
      RES_234X480  = 3'd1,
      RES_220X528  = 3'd2,
      RES_234X960  = 3'd3,
      RES_234X1152 = 3'd4
   } res_e;

   localparam int TW = 8;

   typedef struct packed {
      logic [TW-1:0] hsy_w;
      logic [TW-1:0] oeh_o;
      logic [TW-1:0] oeh_w;
      logic [TW-1:0] ckv_o;
      logic [TW-1:0] ckv_w;
      logic [TW-1:0] oev_o;
      logic [TW-1:0] oev_w;
      logic [TW-1:0] shd_w;
      logic [TW-1:0] cp_o;
   } line_tbl_t;

   localparam int WIN_HSY = 0;
   localparam int WIN_OEH = 1;
   localparam int WIN_CKV = 2;
   localparam int WIN_OEV = 3;
   localparam int WIN_SHD = 4;
   localparam int WIN_CP  = 5;
   localparam int WIN_STP = 6;
   localparam int NWIN    = 7;

   function automatic logic is_hires(input res_e r);
      return (r == RES_234X960) || (r == RES_234X1152);
   endfunction

endpackage

// File: rtl/lcd_mode_table.sv
module lcd_mode_table
   import lcd_tg_pkg::*;
(
   input  res_e      mode,
   output line_tbl_t tbl,
   output logic      hires
);

   always_comb begin
      unique case (mode)
         RES_220X280: tbl = '{hsy_w: 8'd9,  oeh_o: 8'd5,  oeh_w: 8'd2,
                              ckv_o: 8'd4,  ckv_w: 8'd11, oev_o: 8'd3,
                              oev_w: 8'd10, shd_w: 8'd16, cp_o: 8'd6};
         RES_220X528: tbl = '{hsy_w: 8'd18, oeh_o: 8'd8,  oeh_w: 8'd5,
                              ckv_o: 8'd7,  ckv_w: 8'd24, oev_o: 8'd1,
                              oev_w: 8'd14, shd_w: 8'd27, cp_o: 8'd12};
         RES_234X960: tbl = '{hsy_w: 8'd30, oeh_o: 8'd14, oeh_w: 8'd7,
                              ckv_o: 8'd12, ckv_w: 8'd40, oev_o: 8'd4,
                              oev_w: 8'd26, shd_w: 8'd54, cp_o: 8'd20};
         RES_234X1152: tbl = '{hsy_w: 8'd36, oeh_o: 8'd18, oeh_w: 8'd9,
                               ckv_o: 8'd14, ckv_w: 8'd50, oev_o: 8'd12,
                               oev_w: 8'd40, shd_w: 8'd62, cp_o: 8'd26};
         default:     tbl = '{hsy_w: 8'd15, oeh_o: 8'd8,  oeh_w: 8'd3,
                              ckv_o: 8'd6,  ckv_w: 8'd20, oev_o: 8'd2,
                              oev_w: 8'd13, shd_w: 8'd27, cp_o: 8'd10};
      endcase
   end

   assign hires = is_hires(mode);

endmodule

// File: rtl/lcd_line_ctrl.sv
module lcd_line_ctrl
   import lcd_tg_pkg::*;
#(
   parameter int UNIT_W = 10,
   parameter int TPH    = 3,
   parameter int PH_W   = $clog2(2 * TPH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [2:0]        mode_code,
   output logic [UNIT_W-1:0] unit,
   output res_e              mode_q,
   output logic [UNIT_W-1:0] line_len,
   output logic              active,
   output logic [PH_W-1:0]   phase
);

   localparam int SUB_W = $clog2(TPH);
   localparam logic [UNIT_W-1:0] UNIT_MAX = '1;
   localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(TPH - 1);
   localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(2 * TPH - 1);

   logic [SUB_W-1:0] sub_q;
   logic             code_ok;
   res_e             code_res;

   // resolution code decode; unlisted codes are rejected
   always_comb begin
      code_ok  = 1'b1;
      code_res = RES_234X480;
      unique case (mode_code)
         3'b110:  code_res = RES_220X280;
         3'b111:  code_res = RES_234X480;
         3'b100:  code_res = RES_220X528;
         3'b101:  code_res = RES_234X960;
         3'b001:  code_res = RES_234X1152;
         default: code_ok  = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q    <= '0;
         unit     <= UNIT_MAX;
         phase    <= '0;
         mode_q   <= RES_234X480;
         line_len <= '0;
         active   <= 1'b0;
      end else if (line_start) begin
         sub_q  <= '0;
         unit   <= '0;
         phase  <= '0;
         active <= 1'b1;
         if (code_ok) mode_q <= code_res;
         if (!active)               line_len <= '0;
         else if (unit == UNIT_MAX) line_len <= UNIT_MAX;
         else                       line_len <= unit + 1'b1;
      end else begin
         phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
         if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (unit != UNIT_MAX) unit <= unit + 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(mode_q));

endmodule

// File: rtl/lcd_phase_out.sv
module lcd_phase_out #(
   parameter int TPH  = 3,
   parameter int NPH  = 3,
   parameter int PH_W = $clog2(2 * TPH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_start,
   input  logic [PH_W-1:0] phase,
   output logic [NPH-1:0]  ck
);

   localparam int STEP = TPH / NPH;
   localparam int PER  = 2 * TPH;

   for (genvar k = 0; k < NPH; k++) begin : g_ph
      localparam int OFS = k * STEP;
      logic [PH_W:0] rel;
      logic          ck_q;

      assign rel = ({1'b0, phase} >= (PH_W+1)'(OFS))
                 ? ({1'b0, phase} - (PH_W+1)'(OFS))
                 : ({1'b0, phase} + (PH_W+1)'(PER - OFS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ck_q <= 1'b0;
         else        ck_q <= (rel < (PH_W+1)'(TPH));
      end

      assign ck[k] = ck_q;

      if (k < NPH - 1) begin : g_lag
         assert_phase_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ck[k]) && !$past(line_start)) |=> $rose(ck[k+1]));
      end
   end

endmodule

// File: rtl/lcd_window.sv
module lcd_window #(
   parameter int UNIT_W = 10,
   parameter bit INV    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [UNIT_W-1:0] unit,
   input  logic [UNIT_W-1:0] start,
   input  logic [UNIT_W-1:0] width,
   output logic              hit
);

   logic [UNIT_W:0] stop;
   logic            inwin;

   assign stop  = {1'b0, start} + {1'b0, width};
   assign inwin = (unit >= start) && ({1'b0, unit} < stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= en & (INV ? ~inwin : inwin);
   end

   assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !hit);

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
   import lcd_tg_pkg::*;
#(
   parameter int UNIT_W = 10,
   parameter int TPH    = 3,
   parameter int NPH    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_start,
   input  logic [2:0]     mode_sel,
   input  logic           lr_scan,
   output logic [NPH-1:0] src_ck,
   output logic           hsync_n,
   output logic           oe_h,
   output logic           oe_v,
   output logic           gate_ck,
   output logic           cmp_pulse,
   output logic           sh_ctl,
   output logic           start_r,
   output logic           start_r_en,
   output logic           start_l,
   output logic           start_l_en
);

   localparam int PH_W = $clog2(2 * TPH);

   if (TPH < 3 || (TPH % NPH) != 0) begin : g_bad_tph
      $error("lcd_line_timer: TPH must be >= 3 and a multiple of NPH");
   end
   if (UNIT_W <= TW) begin : g_bad_unit
      $error("lcd_line_timer: UNIT_W must exceed the table field width");
   end

   logic [UNIT_W-1:0] unit;
   logic [UNIT_W-1:0] line_len;
   logic              active;
   logic [PH_W-1:0]   phase;
   res_e              mode_q;
   line_tbl_t         tbl;
   logic              hires;
   logic [1:0]        route_q;

   logic [UNIT_W-1:0] w_start [NWIN];
   logic [UNIT_W-1:0] w_width [NWIN];
   logic              w_en    [NWIN];
   logic              w_hit   [NWIN];

   lcd_line_ctrl #(.UNIT_W(UNIT_W), .TPH(TPH), .PH_W(PH_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_code(mode_sel),
      .unit(unit), .mode_q(mode_q), .line_len(line_len), .active(active),
      .phase(phase));

   lcd_mode_table u_tbl (.mode(mode_q), .tbl(tbl), .hires(hires));

   lcd_phase_out #(.TPH(TPH), .NPH(NPH), .PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .phase(phase),
      .ck(src_ck));

   always_comb begin
      w_start[WIN_HSY] = '0;
      w_width[WIN_HSY] = UNIT_W'(tbl.hsy_w);
      w_start[WIN_OEH] = UNIT_W'(tbl.oeh_o);
      w_width[WIN_OEH] = UNIT_W'(tbl.oeh_w);
      w_start[WIN_CKV] = UNIT_W'(tbl.ckv_o);
      w_width[WIN_CKV] = UNIT_W'(tbl.ckv_w);
      w_start[WIN_OEV] = UNIT_W'(tbl.oev_o);
      w_width[WIN_OEV] = UNIT_W'(tbl.oev_w);
      w_start[WIN_SHD] = '0;
      w_width[WIN_SHD] = UNIT_W'(tbl.shd_w);
      w_start[WIN_CP]  = UNIT_W'(tbl.cp_o);
      w_width[WIN_CP]  = line_len >> 1;
      w_start[WIN_STP] = UNIT_W'(tbl.shd_w);
      w_width[WIN_STP] = UNIT_W'(1);
      for (int i = 0; i < NWIN; i++) w_en[i] = active;
      w_en[WIN_SHD] = active & ~hires;
   end

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      lcd_window #(.UNIT_W(UNIT_W), .INV(g == WIN_SHD ? 1'b1 : 1'b0)) u_win (
         .clk(clk), .rst_n(rst_n), .en(w_en[g]), .unit(unit),
         .start(w_start[g]), .width(w_width[g]), .hit(w_hit[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q <= 2'b00;
      else        route_q <= {~lr_scan, lr_scan};
   end

   assign hsync_n    = ~w_hit[WIN_HSY];
   assign oe_h       = w_hit[WIN_OEH];
   assign gate_ck    = w_hit[WIN_CKV];
   assign oe_v       = w_hit[WIN_OEV];
   assign sh_ctl     = w_hit[WIN_SHD];
   assign cmp_pulse  = w_hit[WIN_CP];
   assign start_r    = w_hit[WIN_STP] & route_q[0];
   assign start_r_en = route_q[0];
   assign start_l    = w_hit[WIN_STP] & route_q[1];
   assign start_l_en = route_q[1];

   assert_shd_hires_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hires |=> !sh_ctl);

   assert_hsync_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hsync_n) |-> $past(line_start, 2));

endmodule

// File: tb/sim_lcd_line_timer.sv
`timescale 1ns/1ps
module sim_lcd_line_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic [2:0] mode_sel = 3'b111;
   logic       lr_scan = 1'b1;
   logic [2:0] src_ck;
   logic       hsync_n, oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl;
   logic       start_r, start_r_en, start_l, start_l_en;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // code, hsy, oeh_o, oeh_w, ckv_o, ckv_w, oev_o, oev_w, shd, cp_o, hires
   localparam int VEC [5][11] = '{
      '{6,  9,  5, 2,  4, 11,  3, 10, 16,  6, 0},
      '{7, 15,  8, 3,  6, 20,  2, 13, 27, 10, 0},
      '{4, 18,  8, 5,  7, 24,  1, 14, 27, 12, 0},
      '{5, 30, 14, 7, 12, 40,  4, 26, 54, 20, 1},
      '{1, 36, 18, 9, 14, 50, 12, 40, 62, 26, 1}
   };

   int fst [7];
   int cnt [7];
   int ck_err;
   int route_err;

   lcd_line_timer u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_sel(mode_sel),
      .lr_scan(lr_scan), .src_ck(src_ck), .hsync_n(hsync_n), .oe_h(oe_h),
      .oe_v(oe_v), .gate_ck(gate_ck), .cmp_pulse(cmp_pulse), .sh_ctl(sh_ctl),
      .start_r(start_r), .start_r_en(start_r_en), .start_l(start_l),
      .start_l_en(start_l_en));

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic start_line();
      line_start = 1'b1;
      @(posedge clk); #1;
      line_start = 1'b0;
   endtask

   task automatic run_line(input int n, input int mid_code);
      logic [6:0] s;
      for (int i = 0; i < 7; i++) begin fst[i] = -1; cnt[i] = 0; end
      ck_err = 0;
      route_err = 0;
      for (int j = 1; j < 3 * n; j++) begin
         @(posedge clk); #1;
         if (j == 4 && mid_code >= 0) mode_sel = 3'(mid_code);
         if (j <= 12) begin
            int ph = (j - 1) % 6;
            if (src_ck[0] != (ph < 3) || src_ck[1] != (ph >= 1 && ph <= 3) ||
                src_ck[2] != (ph >= 2 && ph <= 4)) ck_err++;
         end
         if (j % 3 == 2) begin
            int u = j / 3;
            s = {lr_scan ? start_r : start_l, cmp_pulse, sh_ctl, oe_v,
                 gate_ck, oe_h, ~hsync_n};
            for (int k = 0; k < 7; k++) begin
               if (s[k]) begin
                  cnt[k]++;
                  if (fst[k] < 0) fst[k] = u;
               end
            end
            if (lr_scan) begin
               if (start_l || start_l_en || !start_r_en) route_err++;
            end else begin
               if (start_r || start_r_en || !start_l_en) route_err++;
            end
         end
      end
   endtask

   task automatic check_line(input int v, input int prev_n, input int n);
      int cpw;
      chk(fst[0] == 0 && cnt[0] == VEC[v][1], "R3", "hsync low units",
          cnt[0], VEC[v][1]);
      chk(fst[1] == VEC[v][2], "R4", "oe_h first unit", fst[1], VEC[v][2]);
      chk(cnt[1] == VEC[v][3], "R4", "oe_h units", cnt[1], VEC[v][3]);
      chk(fst[2] == VEC[v][4], "R4", "gate_ck first unit", fst[2], VEC[v][4]);
      chk(cnt[2] == VEC[v][5], "R4", "gate_ck units", cnt[2], VEC[v][5]);
      chk(fst[3] == VEC[v][6], "R4", "oe_v first unit", fst[3], VEC[v][6]);
      chk(cnt[3] == VEC[v][7], "R4", "oe_v units", cnt[3], VEC[v][7]);
      if (VEC[v][10] != 0) begin
         chk(cnt[4] == 0, "R5", "sh_ctl units (hires)", cnt[4], 0);
      end else begin
         chk(fst[4] == VEC[v][8] && cnt[4] == n - VEC[v][8], "R5",
             "sh_ctl first unit", fst[4], VEC[v][8]);
      end
      cpw = prev_n / 2;
      if (cpw > n - VEC[v][9]) cpw = n - VEC[v][9];
      chk(cnt[5] == cpw, "R7", "cmp_pulse units", cnt[5], cpw);
      if (cpw > 0) chk(fst[5] == VEC[v][9], "R7", "cmp_pulse first unit",
                       fst[5], VEC[v][9]);
      chk(fst[6] == VEC[v][8] && cnt[6] == 1, "R6", "start pulse unit",
          fst[6], VEC[v][8]);
      chk(route_err == 0, "R6", "start pin routing errors", route_err, 0);
      chk(ck_err == 0, "R2", "shift clock phase errors", ck_err, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9: reset levels
      chk(hsync_n == 1'b1 && {oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl} == 5'b0,
          "R9", "reset levels", {hsync_n, oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl},
          6'b100000);
      chk({src_ck, start_r, start_r_en, start_l, start_l_en} == 7'b0, "R9",
          "reset clocks and start pins", {src_ck, start_r, start_r_en, start_l,
          start_l_en}, 0);
      rst_n = 1'b1;
      repeat (10) @(posedge clk);
      #1;
      // R9: idle until first line start
      chk(hsync_n == 1'b1 && {oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl,
          start_r, start_l} == 7'b0, "R9", "idle before first line",
          {hsync_n, oe_h, oe_v, gate_ck, cmp_pulse, sh_ctl, start_r, start_l},
          8'h80);

      // table walk: R1 for every mode, both scan directions
      for (int i = 0; i < 5; i++) begin
         lr_scan = (i % 2) == 0;
         mode_sel = 3'(VEC[i][0]);
         start_line();
         run_line(120, -1);
         if (i == 0) check_line(i, 0, 120);  // R7 first line after reset: no compare pulse
         start_line();
         run_line(120, -1);
         check_line(i, 120, 120);           // R1 mode table
      end

      // R8: rejected codes keep the 234x1152 table
      for (int c = 0; c < 4; c++) begin
         if (c == 1) continue;
         mode_sel = 3'(c);
         start_line();
         run_line(120, -1);
         check_line(4, 120, 120);
      end

      // R8: mid-line change waits for the next line start
      lr_scan = 1'b0;
      mode_sel = 3'b110;
      start_line();
      run_line(120, 3'b111);
      check_line(0, 120, 120);
      start_line();
      run_line(120, -1);
      check_line(1, 120, 120);

      // R7: compare pulse follows previous line length
      start_line();
      run_line(90, -1);
      check_line(1, 120, 90);
      start_line();
      run_line(90, -1);
      check_line(1, 90, 90);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule